// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Masked Half-Word Writes

This block sits between a 32-bit register port and 118 general-purpose pads, which are grouped into four banks of 32, 22, 32 and 32 pins. Every bank keeps its own direction, output-enable and output-latch registers and a set of interrupt mask bits. A pad drives its latch value only when the pin is configured as an output and its output enable is on. Software reads the pad levels back through a two-flop synchronizer.

The output latch is never written as a whole word. Each bank has two write-only ports, one for pins 0–15 and one for pins 16–31. In each port the upper half-word selects the pins to leave alone and the lower half-word carries the new levels. A single pin can therefore be toggled without first reading the latch. The interrupt mask uses the same set-and-clear idea: a write-only arm port clears mask bits, a write-only disarm port sets them, and a read-only view shows the result.

Top module: `gpio_multibank`

## Requirements
- R1: After reset, every direction, output-enable and latch bit is 0, except that bank 0 pins 7 and 8 read 1 in direction. Every implemented interrupt mask bit reads 1.
- R2: A write to the low-half port at byte offset 8×bank updates latch pins 0–15. Bits 31:16 are a mask and bits 15:0 are data. A pin takes its data bit when its mask bit is 0 and keeps its value when the mask bit is 1.
- R3: The high-half port at 8×bank+4 works the same way on latch pins 16–31: data bit i and mask bit 16+i act on pin 16+i.
- R4: Direction is read/write at 0x204+0x40×bank, where 1 means output. Output enable is read/write at 0x208+0x40×bank. padOe of a pin is its direction bit AND its enable bit. padOut carries the latch.
- R5: Bank 0 pins 7 and 8 always read 1 in direction. A write of 0 to those bits is ignored.
- R6: A read at 0x060+4×bank returns the bank's pad levels after two synchronizer flops. A pad change driven just before edge k is returned by a read issued at edge k+2.
- R7: The interrupt mask reads at 0x20C+0x40×bank. Writing 1s to 0x210+0x40×bank clears the matching mask bits. Writing 1s to 0x214+0x40×bank sets them. Zero bits in either write leave the mask unchanged.
- R8: In bank 1 (22 pins), bits 31:22 of every register read back as 0, and writes to those bits are ignored.
- R9: Reads of write-only ports, of misaligned addresses and of unmapped addresses return 0. Writes to read-only or unmapped addresses change no state.
- R10: regRdData holds the selected register one cycle after regRdEn is sampled high, and it is 0 in a cycle that follows no read.
- R11: When a read and a write to the same register happen in the same cycle, the read returns the value the register had before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address shared by read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| padIn | input | 118 | Pad input levels (asynchronous) |
| padOut | output | 118 | Pad output levels from the latches |
| padOe | output | 118 | Pad drive enables |

## Verification
The host port has one address shared by its read and write strobes, so a read and a write can target the same register in the same cycle. The bench raises both strobes together on the output-enable register of bank 2. It expects the read to return the old contents and a follow-up read to return the new value. A second overlap comes from the synchronizer: the bench changes the pad inputs in the same cycle that it issues a read, then reads twice more. It expects the old level, the old level again, and then the new one, which checks the flop count exactly.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;

  localparam int NUM_BANKS  = 4;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int ADDR_W     = 12;
  localparam int BANK_WIDTH [NUM_BANKS] = '{32, 22, 32, 32};

  // address map
  localparam logic [ADDR_W-1:0] HALF_PORT_END = ADDR_W'(8 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] PINS_BASE     = ADDR_W'('h060);
  localparam logic [ADDR_W-1:0] PINS_END      = ADDR_W'('h060 + 4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] CFG_BASE      = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] CFG_END       = ADDR_W'('h200 + 'h40 * NUM_BANKS);
  localparam logic [5:0] SUB_DIR   = 6'h04;
  localparam logic [5:0] SUB_OE    = 6'h08;
  localparam logic [5:0] SUB_IMASK = 6'h0C;
  localparam logic [5:0] SUB_IARM  = 6'h10;
  localparam logic [5:0] SUB_IDIS  = 6'h14;

  localparam logic [DATA_W-1:0] BANK0_FIXED_OUT = 32'h0000_0180;

  function automatic int bankBase(int b);
    int acc = 0;
    for (int i = 0; i < b; i++) acc += BANK_WIDTH[i];
    return acc;
  endfunction

  localparam int TOTAL_PINS = bankBase(NUM_BANKS);

  function automatic logic [DATA_W-1:0] implMask(int b);
    if (BANK_WIDTH[b] >= DATA_W) return '1;
    return (DATA_W'(1) << BANK_WIDTH[b]) - DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] fixedOutMask(int b);
    return (b == 0) ? BANK0_FIXED_OUT : '0;
  endfunction

  // keep bits under a set mask, take data where the mask is clear
  function automatic logic [HALF_W-1:0] halfMerge(logic [HALF_W-1:0] old,
                                                  logic [DATA_W-1:0] word);
    logic [HALF_W-1:0] keep;
    keep = word[DATA_W-1:HALF_W];
    return (old & keep) | (word[HALF_W-1:0] & ~keep);
  endfunction

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PINS,
    RD_DIR,
    RD_OE,
    RD_IMASK
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  loWr;
    logic [NUM_BANKS-1:0]  hiWr;
    logic [NUM_BANKS-1:0]  dirWr;
    logic [NUM_BANKS-1:0]  oeWr;
    logic [NUM_BANKS-1:0]  armWr;
    logic [NUM_BANKS-1:0]  disWr;
    rdSel_e                rdSel;
    logic [BANK_IDX_W-1:0] rdBank;
  } strobe_t;

endpackage

// File: rtl/gpio_mb_ctrl.sv
module gpio_mb_ctrl
  import gpio_mb_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobes
);

  logic                  aligned;
  logic                  inHalf;
  logic                  inPins;
  logic                  inCfg;
  logic [BANK_IDX_W-1:0] halfIdx;
  logic [BANK_IDX_W-1:0] pinsIdx;
  logic [BANK_IDX_W-1:0] cfgIdx;
  logic [5:0]            cfgSub;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign inHalf  = aligned && (regAddr < HALF_PORT_END);
  assign inPins  = aligned && (regAddr >= PINS_BASE) && (regAddr < PINS_END);
  assign inCfg   = aligned && (regAddr >= CFG_BASE) && (regAddr < CFG_END);
  assign halfIdx = regAddr[3 +: BANK_IDX_W];
  assign pinsIdx = regAddr[2 +: BANK_IDX_W];
  assign cfgIdx  = regAddr[6 +: BANK_IDX_W];
  assign cfgSub  = regAddr[5:0];

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_NONE;
    strobes.rdBank = '0;

    if (regWrEn) begin
      if (inHalf) begin
        if (regAddr[2]) strobes.hiWr[halfIdx] = 1'b1;
        else            strobes.loWr[halfIdx] = 1'b1;
      end
      if (inCfg) begin
        unique case (cfgSub)
          SUB_DIR:  strobes.dirWr[cfgIdx] = 1'b1;
          SUB_OE:   strobes.oeWr[cfgIdx]  = 1'b1;
          SUB_IARM: strobes.armWr[cfgIdx] = 1'b1;
          SUB_IDIS: strobes.disWr[cfgIdx] = 1'b1;
          default:  ;
        endcase
      end
    end

    if (regRdEn) begin
      if (inPins) begin
        strobes.rdSel  = RD_PINS;
        strobes.rdBank = pinsIdx;
      end else if (inCfg) begin
        strobes.rdBank = cfgIdx;
        unique case (cfgSub)
          SUB_DIR:   strobes.rdSel = RD_DIR;
          SUB_OE:    strobes.rdSel = RD_OE;
          SUB_IMASK: strobes.rdSel = RD_IMASK;
          default:   strobes.rdSel = RD_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_mb_datapath.sv
module gpio_mb_datapath
  import gpio_mb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [TOTAL_PINS-1:0] padIn,
  output logic [TOTAL_PINS-1:0] padOut,
  output logic [TOTAL_PINS-1:0] padOe,
  output logic [DATA_W-1:0]     regRdData
);

  logic [DATA_W-1:0] pinsView  [NUM_BANKS];
  logic [DATA_W-1:0] dirView   [NUM_BANKS];
  logic [DATA_W-1:0] oeView    [NUM_BANKS];
  logic [DATA_W-1:0] imaskView [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int                W     = BANK_WIDTH[b];
    localparam int                BASE  = bankBase(b);
    localparam logic [DATA_W-1:0] IMPL  = implMask(b);
    localparam logic [DATA_W-1:0] FIXED = fixedOutMask(b);

    logic [DATA_W-1:0] dirQ, oeQ, latQ, imaskQ;
    logic [DATA_W-1:0] syncA, syncB, padExt, latNext;

    always_comb begin
      padExt          = '0;
      padExt[W-1:0]   = padIn[BASE +: W];
    end

    always_comb begin
      latNext = latQ;
      if (strobes.loWr[b]) latNext[HALF_W-1:0]      = halfMerge(latQ[HALF_W-1:0], regWrData);
      if (strobes.hiWr[b]) latNext[DATA_W-1:HALF_W] = halfMerge(latQ[DATA_W-1:HALF_W], regWrData);
      latNext = latNext & IMPL;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ   <= FIXED;
        oeQ    <= '0;
        latQ   <= '0;
        imaskQ <= IMPL;
        syncA  <= '0;
        syncB  <= '0;
      end else begin
        syncA <= padExt;
        syncB <= syncA;
        latQ  <= latNext;
        if (strobes.dirWr[b]) dirQ <= (regWrData & IMPL) | FIXED;
        if (strobes.oeWr[b])  oeQ  <= regWrData & IMPL;
        if (strobes.armWr[b])      imaskQ <= imaskQ & ~regWrData;
        else if (strobes.disWr[b]) imaskQ <= (imaskQ | regWrData) & IMPL;
      end
    end

    assign padOut[BASE +: W] = latQ[W-1:0];
    assign padOe[BASE +: W]  = dirQ[W-1:0] & oeQ[W-1:0];

    assign pinsView[b]  = syncB;
    assign dirView[b]   = dirQ;
    assign oeView[b]    = oeQ;
    assign imaskView[b] = imaskQ;
  end

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    unique case (strobes.rdSel)
      RD_PINS:  rdNext = pinsView[strobes.rdBank];
      RD_DIR:   rdNext = dirView[strobes.rdBank];
      RD_OE:    rdNext = oeView[strobes.rdBank];
      RD_IMASK: rdNext = imaskView[strobes.rdBank];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= rdNext;
  end

endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_mb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [TOTAL_PINS-1:0] padIn,
  output logic [TOTAL_PINS-1:0] padOut,
  output logic [TOTAL_PINS-1:0] padOe
);

  strobe_t strobes;

  gpio_mb_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  gpio_mb_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .regRdData (regRdData)
  );

endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [11:0] regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic [15:0] lowOut,
  input logic [31:0] bank0Oe
);

  // R10: no read sampled means zero read data next cycle
  p_rd_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> (regRdData == 32'h0));

  // R9: reads of the write-only half-word ports return zero
  p_wo_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr < 12'h020) |=> (regRdData == 32'h0));

  // R8: unimplemented upper bits of bank 1 read as zero
  p_bank1_upper_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (regAddr == 12'h064 || regAddr == 12'h244 ||
                 regAddr == 12'h248 || regAddr == 12'h24C))
    |=> (regRdData[31:22] == 10'h0));

  // R2: masked merge on bank 0 low half
  p_low_half_merge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 12'h000)
    |=> (lowOut == $past((lowOut & regWrData[31:16]) | (regWrData[15:0] & ~regWrData[31:16]))));

  // R5: fixed-output pins drive once their enables are set
  p_fixed_out_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 12'h208 && regWrData[8:7] == 2'b11)
    |=> (bank0Oe[8:7] == 2'b11));

  // R4: clearing all enables silences the bank's drivers
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 12'h208 && regWrData == 32'h0)
    |=> (bank0Oe == 32'h0));

endmodule

bind gpio_multibank gpio_multibank_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .lowOut    (padOut[15:0]),
  .bank0Oe   (padOe[31:0])
);

// File: tb/test_gpio_multibank.sv
`timescale 1ns/1ps
module test_gpio_multibank;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic         regRdEn = 1'b0;
  logic [11:0]  regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [117:0] padIn = '0;
  logic [117:0] padOut;
  logic [117:0] padOe;

  always #2.5 clk = ~clk;

  gpio_multibank i_gpio_multibank (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per sampled read
  always @(posedge clk) rdSeen <= regRdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: unexpected read data %08h expected none", regRdData);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string       t = tagQ.pop_front();
        check(t, regRdData, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 padOut after reset", padOut[31:0], 32'h0);
    check("R1 padOe after reset", padOe[31:0], 32'h0);
    rd(12'h204, 32'h0000_0180, "R1 R5 bank0 dir reset");
    rd(12'h208, 32'h0, "R1 bank0 oe reset");
    rd(12'h20C, 32'hFFFF_FFFF, "R1 bank0 imask reset");
    rd(12'h24C, 32'h003F_FFFF, "R1 R8 bank1 imask reset");

    // R10 idle cycle after a read
    idle(1);
    check("R10 read data zero when idle", regRdData, 32'h0);

    // R5 fixed direction bits
    wr(12'h204, 32'h0);
    rd(12'h204, 32'h0000_0180, "R5 clear attempt ignored");

    // R4 enable gating
    wr(12'h204, 32'hFFFF_0000);
    wr(12'h208, 32'h0000_FFFF);
    check("R4 padOe is dir AND oe", padOe[31:0], 32'h0000_0180);
    rd(12'h208, 32'h0000_FFFF, "R4 oe readback");
    wr(12'h208, 32'hFFFF_FFFF);
    check("R4 padOe all enabled", padOe[31:0], 32'hFFFF_0180);

    // R2 low half
    wr(12'h000, 32'h0000_A5A5);
    check("R2 low half full write", {16'h0, padOut[15:0]}, 32'h0000_A5A5);
    wr(12'h000, 32'hFF00_1234);
    check("R2 low half masked merge", {16'h0, padOut[15:0]}, 32'h0000_A534);
    check("R2 high pins untouched", {16'h0, padOut[31:16]}, 32'h0);

    // R3 high half on bank 2
    wr(12'h014, 32'h0000_BEEF);
    check("R3 high half write", {16'h0, padOut[70 +: 16]}, 32'h0000_BEEF);
    wr(12'h014, 32'h00FF_0000);
    check("R3 high half masked merge", {16'h0, padOut[70 +: 16]}, 32'h0000_00EF);
    check("R3 bank2 low pins untouched", {16'h0, padOut[54 +: 16]}, 32'h0);

    // R8 bank 1 narrow
    wr(12'h00C, 32'h0000_FFFF);
    check("R8 bank1 latch limited", {10'h0, padOut[32 +: 22]}, 32'h003F_0000);
    wr(12'h244, 32'hFFFF_FFFF);
    rd(12'h244, 32'h003F_FFFF, "R8 bank1 dir upper bits");

    // R6 synchronizer latency on bank 3
    padIn[86 +: 32] = 32'h1111_2222;
    idle(3);
    rd(12'h06C, 32'h1111_2222, "R6 stable pad level");
    padIn[86 +: 32] = 32'hCAFE_F00D;
    rd(12'h06C, 32'h1111_2222, "R6 first read after change");
    rd(12'h06C, 32'h1111_2222, "R6 second read after change");
    rd(12'h06C, 32'hCAFE_F00D, "R6 third read after change");

    // R7 interrupt arm / disarm
    wr(12'h210, 32'h0000_00FF);
    rd(12'h20C, 32'hFFFF_FF00, "R7 arm clears");
    wr(12'h214, 32'h0000_000F);
    rd(12'h20C, 32'hFFFF_FF0F, "R7 disarm sets");
    wr(12'h214, 32'hFFFF_FFFF);
    rd(12'h20C, 32'hFFFF_FFFF, "R7 disarm all");
    wr(12'h250, 32'hFFFF_FFFF);
    rd(12'h24C, 32'h0, "R7 bank1 armed");

    // R9 write-only, misaligned, unmapped
    rd(12'h000, 32'h0, "R9 read of half port");
    rd(12'h210, 32'h0, "R9 read of arm port");
    rd(12'h218, 32'h0, "R9 read unmapped cfg");
    rd(12'h300, 32'h0, "R9 read unmapped");
    rd(12'h206, 32'h0, "R9 read misaligned");
    wr(12'h060, 32'hFFFF_FFFF);
    wr(12'h20C, 32'h0);
    wr(12'h300, 32'h0000_0000);
    wr(12'h002, 32'h0000_0000);
    check("R9 latch unchanged", {16'h0, padOut[15:0]}, 32'h0000_A534);
    rd(12'h20C, 32'hFFFF_FFFF, "R9 imask unchanged");
    rd(12'h204, 32'hFFFF_0180, "R9 dir unchanged");

    // R11 same-cycle read and write
    regWrEn = 1'b1; regRdEn = 1'b1; regAddr = 12'h288; regWrData = 32'h1234_5678;
    expQ.push_back(32'h0); tagQ.push_back("R11 read sees old value");
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    rd(12'h288, 32'h1234_5678, "R11 write took effect");

    idle(3);
    check("R10 scoreboard drained", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule